// File: doc/BRIEF.md
# Programmable Stage-Select Interval Timer

This block divides its input clock with a 16-bit synchronous binary counter and brings out one counter stage as the timer output. A 2-bit select input picks stage 8, 10, 13 or 16. The stage number is N. Stage N is counter bit N-1, which completes one full cycle every 2^N clocks.

The output has two modes. In recycle mode the output is a continuous square wave at the clock frequency divided by 2^N. In one-shot mode the output makes a single change 2^(N-1) clocks after a reset. It then holds that level until the next master reset, or until recycle mode is selected. A polarity input sets whether the output starts high or low after reset.

The active-high master reset clears the count at once. Counting restarts on the first rising edge after the reset is released. An active-low power-up input `por_n` models power-on. When the auto-reset-disable input is high, the counter stays idle after power-up until a master reset pulse has been seen. When it is low, counting starts straight from power-up.

The control sequencer has four named states:
- `ST_BOOT`: entered on power-up.
- `ST_ARMED`: waiting for a master reset.
- `ST_RUN`: counting, with the output following the selected stage.
- `ST_LATCHED`: one-shot change done, output frozen.

The transitions are:
- boot→run, when auto reset is enabled or master reset is high.
- boot→armed, when auto reset is disabled.
- armed→run, when master reset is seen high at a clock edge.
- run→latched, in one-shot mode when the selected stage is high.
- latched→run, when recycle mode is selected or master reset is high.

Top module: `stage_tap_timer`

## Requirements
- R1: While counting is enabled, the counter advances by one on every rising clock edge. Stage N is counter bit N-1.
- R2: The select code `sel[1:0]` maps to stages as follows: 2'b00 picks stage 13, 2'b01 picks stage 10, 2'b10 picks stage 8, and 2'b11 picks stage 16.
- R3: With `mode_recycle`=1, the output first changes at the 2^(N-1)-th rising edge after reset release. It then changes every 2^(N-1) edges, which gives a period of 2^N clocks.
- R4: With `mode_recycle`=0, the output changes once, at the 2^(N-1)-th edge after reset release. It then holds that level through later counter wraps.
- R5: After reset, the output equals `start_high`. With `start_high`=0, the output level is the selected counter bit. With `start_high`=1, it is the inverse of that bit.
- R6: While `mres` is high, the count and the one-shot latch are cleared at once and the output sits at its start level. The first count is on the first rising edge after `mres` falls.
- R7: With `auto_off`=1, the counter does not advance after `por_n` rises until `mres` has been high across a rising edge and has been released.
- R8: With `auto_off`=0, the counter starts from zero at `por_n` release. Its first count is on the first rising edge after release.
- R9: In one-shot mode, setting `mode_recycle`=1 releases the latch. The output then follows the selected stage again.
- R10: A change of `sel` while counting switches the tap at once, without clearing the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock, rising edge active |
| por_n | input | 1 | Active-low power-up reset |
| mres | input | 1 | Active-high master reset |
| auto_off | input | 1 | 1 = wait for a master reset before counting after power-up |
| sel | input | 2 | Stage select code (see R2) |
| mode_recycle | input | 1 | 1 = square wave, 0 = one-shot |
| start_high | input | 1 | Output level right after reset |
| tmr_out | output | 1 | Timer output |

## Verification
The bench places every edge of the output at an exact clock count after reset release, for every select code and both modes. A design that is off by one edge in its reset release or its tap index would therefore show the change one edge early or late, or at double or half the interval. The one-shot runs carry on past a counter wrap of the selected stage, so a latch that fails to hold shows up as an unexpected second edge. Further runs cover the following:
- Switching the select in mid-count: a design that resets or ignores the new select would toggle at the old stage.
- Leaving one-shot for recycle mode: a design that keeps the latch would miss the expected falling edge.
- Idle period with auto reset disabled: a counter that runs during this period would produce output edges.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
    typedef enum logic [1:0] {
        ST_BOOT    = 2'd0,
        ST_ARMED   = 2'd1,
        ST_RUN     = 2'd2,
        ST_LATCHED = 2'd3
    } tmr_state_e;

    localparam int TMR_NUM_SEL = 4;
    localparam int TMR_STG_W   = 5;
endpackage

// File: rtl/tmr_counter.sv
`timescale 1ns/1ps
module tmr_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             en,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk or posedge clr) begin
        if (clr) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R1: one step per enabled edge
    a_r1_count_step: assert property (@(posedge clk) disable iff (clr)
        en |=> (cnt == CNT_W'($past(cnt) + 1'b1)));
    a_r1_count_hold: assert property (@(posedge clk) disable iff (clr)
        !en |=> $stable(cnt));
endmodule

// File: rtl/tmr_tap_mux.sv
`timescale 1ns/1ps
module tmr_tap_mux
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter logic [TMR_NUM_SEL-1:0][TMR_STG_W-1:0] STAGES =
        {5'd16, 5'd8, 5'd10, 5'd13}
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [1:0]       sel,
    output logic             tap
);
    logic [TMR_NUM_SEL-1:0] taps;

    for (genvar i = 0; i < TMR_NUM_SEL; i++) begin : g_tap
        localparam int BIT_IDX = int'(STAGES[i]) - 1;
        assign taps[i] = cnt[BIT_IDX];
    end

    assign tap = taps[sel];
endmodule

// File: rtl/tmr_ctrl_fsm.sv
`timescale 1ns/1ps
module tmr_ctrl_fsm
    import tmr_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic mres,
    input  logic auto_off,
    input  logic mode_recycle,
    input  logic tap,
    output logic cnt_en,
    output logic latched,
    output tmr_state_e state
);
    tmr_state_e nxt;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state <= ST_BOOT;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_BOOT:    nxt = (auto_off && !mres) ? ST_ARMED : ST_RUN;
            ST_ARMED:   if (mres) nxt = ST_RUN;
            ST_RUN:     if (!mode_recycle && tap && !mres) nxt = ST_LATCHED;
            ST_LATCHED: if (mode_recycle || mres) nxt = ST_RUN;
            default:    nxt = ST_BOOT;
        endcase
    end

    always_comb begin
        cnt_en  = 1'b0;
        latched = 1'b0;
        unique case (state)
            ST_BOOT:    cnt_en = !auto_off;
            ST_ARMED:   cnt_en = 1'b0;
            ST_RUN:     cnt_en = 1'b1;
            ST_LATCHED: begin
                cnt_en  = 1'b1;
                latched = !mres;
            end
            default:    cnt_en = 1'b0;
        endcase
    end

    // R4: latch holds while one-shot and no master reset
    a_r4_latch_hold: assert property (@(posedge clk) disable iff (!por_n)
        (state == ST_LATCHED && !mode_recycle && !mres) |=> (state == ST_LATCHED));
    // R9: recycle mode releases the latch
    a_r9_leave_latch: assert property (@(posedge clk) disable iff (!por_n)
        (state == ST_LATCHED && mode_recycle) |=> (state == ST_RUN));
    // R7: armed state is left only through master reset
    a_r7_armed_wait: assert property (@(posedge clk) disable iff (!por_n)
        (state == ST_ARMED && !mres) |=> (state == ST_ARMED));
endmodule

// File: rtl/stage_tap_timer.sv
`timescale 1ns/1ps
module stage_tap_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter logic [TMR_NUM_SEL-1:0][TMR_STG_W-1:0] STAGES =
        {5'd16, 5'd8, 5'd10, 5'd13}
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       mres,
    input  logic       auto_off,
    input  logic [1:0] sel,
    input  logic       mode_recycle,
    input  logic       start_high,
    output logic       tmr_out
);
    logic             cnt_clr;
    logic             cnt_en;
    logic             latched;
    logic             tap;
    logic [CNT_W-1:0] cnt;
    tmr_state_e       state;

    assign cnt_clr = !por_n || mres;

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk (clk),
        .clr (cnt_clr),
        .en  (cnt_en),
        .cnt (cnt)
    );

    tmr_tap_mux #(.CNT_W(CNT_W), .STAGES(STAGES)) u_mux (
        .cnt (cnt),
        .sel (sel),
        .tap (tap)
    );

    tmr_ctrl_fsm u_fsm (
        .clk          (clk),
        .por_n        (por_n),
        .mres         (mres),
        .auto_off     (auto_off),
        .mode_recycle (mode_recycle),
        .tap          (tap),
        .cnt_en       (cnt_en),
        .latched      (latched),
        .state        (state)
    );

    assign tmr_out = start_high ^ (latched | tap);

    // R6: master reset holds the count at zero
    a_r6_mres_clear: assert property (@(posedge clk) disable iff (!por_n)
        mres |-> (cnt == '0));
    // R5: during master reset the output shows the start level
    a_r5_start_level: assert property (@(posedge clk) disable iff (!por_n)
        mres |-> (tmr_out == start_high));
    // R7: no counting while armed
    a_r7_armed_idle: assert property (@(posedge clk) disable iff (cnt_clr)
        (state == ST_ARMED) |-> (cnt == '0));
endmodule

// File: tb/stage_tap_timer_tb.sv
`timescale 1ns/1ps
module stage_tap_timer_tb_top;
    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       mres = 1'b0;
    logic       auto_off = 1'b1;
    logic [1:0] sel = 2'b10;
    logic       mode_recycle = 1'b1;
    logic       start_high = 1'b0;
    logic       tmr_out;

    int checks = 0;
    int errors = 0;
    int edge_n = 0;
    bit mon_en = 1'b0;
    logic prev_out = 1'b0;

    typedef struct {
        int    at;
        logic  val;
        string req;
    } exp_t;
    exp_t expq[$];

    always #5 clk = ~clk;

    stage_tap_timer dut_i (
        .clk          (clk),
        .por_n        (por_n),
        .mres         (mres),
        .auto_off     (auto_off),
        .sel          (sel),
        .mode_recycle (mode_recycle),
        .start_high   (start_high),
        .tmr_out      (tmr_out)
    );

    // edges since reset release
    always @(posedge clk) begin
        if (!por_n || mres) edge_n <= 0;
        else                edge_n <= edge_n + 1;
    end

    task automatic check(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at edge %0d", req, act, exp, edge_n);
        end
    endtask

    // monitor: every output edge must match the front of the scoreboard
    always @(negedge clk) begin
        if (mon_en && tmr_out !== prev_out) begin
            checks++;
            if (expq.size() == 0) begin
                errors++;
                $display("FAIL unexpected: actual edge to %b at %0d expected none", tmr_out, edge_n);
            end else begin
                exp_t e;
                e = expq.pop_front();
                if (e.at != edge_n || e.val !== tmr_out) begin
                    errors++;
                    $display("FAIL %s: actual %b at edge %0d expected %b at edge %0d",
                             e.req, tmr_out, edge_n, e.val, e.at);
                end
            end
            prev_out = tmr_out;
        end
    end

    task automatic push(input int at, input logic val, input string req);
        exp_t e;
        e.at = at; e.val = val; e.req = req;
        expq.push_back(e);
    endtask

    task automatic restart(input logic [1:0] s, input logic m, input logic p);
        @(negedge clk); #2;
        mon_en = 1'b0;
        mres = 1'b1;
        sel = s; mode_recycle = m; start_high = p;
        repeat (3) @(negedge clk);
        #1;
        check(tmr_out, p, "R5 start level");
        #1;
        mres = 1'b0;
        prev_out = p;
        mon_en = 1'b1;
    endtask

    task automatic run_to(input int n);
        while (edge_n < n) @(negedge clk);
    endtask

    task automatic close_case(input string req);
        checks++;
        if (expq.size() != 0) begin
            errors++;
            $display("FAIL %s: actual %0d edges pending expected 0", req, expq.size());
        end
        expq.delete();
    endtask

    initial begin
        // R7: auto reset disabled, idle after power-up
        repeat (3) @(negedge clk);
        #2 por_n = 1'b1;
        prev_out = 1'b0;
        mon_en = 1'b1;
        repeat (400) @(negedge clk);
        check(tmr_out, 1'b0, "R7 idle level");
        close_case("R7");

        // R3 R2 stage 8 recycle, start low (R6 first count after release)
        restart(2'b10, 1'b1, 1'b0);
        push(128, 1'b1, "R3/R6 stage8"); push(256, 1'b0, "R3 stage8");
        push(384, 1'b1, "R3 stage8");    push(512, 1'b0, "R3 stage8");
        run_to(520); close_case("R2 stage8");

        // R5 stage 10 recycle, start high
        restart(2'b01, 1'b1, 1'b1);
        push(512, 1'b0, "R5 stage10"); push(1024, 1'b1, "R3 stage10");
        run_to(1030); close_case("R2 stage10");

        // stage 13 recycle both polarities
        restart(2'b00, 1'b1, 1'b0);
        push(4096, 1'b1, "R3 stage13"); push(8192, 1'b0, "R3 stage13");
        run_to(8200); close_case("R2 stage13");
        restart(2'b00, 1'b1, 1'b1);
        push(4096, 1'b0, "R5 stage13"); push(8192, 1'b1, "R5 stage13");
        run_to(8200); close_case("R5 stage13");

        // stage 16 recycle start high
        restart(2'b11, 1'b1, 1'b1);
        push(32768, 1'b0, "R3 stage16"); push(65536, 1'b1, "R3 stage16");
        run_to(65540); close_case("R2 stage16");

        // R4 one-shot stage 8, then R9 back to recycle
        restart(2'b10, 1'b0, 1'b0);
        push(128, 1'b1, "R4 stage8");
        run_to(400);
        close_case("R4 hold past wrap");
        check(tmr_out, 1'b1, "R4 latched level");
        #2 mode_recycle = 1'b1;
        push(512, 1'b0, "R9 release");
        run_to(520); close_case("R9");

        // one-shot stage 10 start high
        restart(2'b01, 1'b0, 1'b1);
        push(512, 1'b0, "R4 stage10");
        run_to(1500); close_case("R4 stage10");

        // one-shot stage 13 start low, then R6 mres clears latch
        restart(2'b00, 1'b0, 1'b0);
        push(4096, 1'b1, "R4 stage13");
        run_to(9000); close_case("R4 stage13");
        #2 mon_en = 1'b0; mres = 1'b1;
        #1 check(tmr_out, 1'b0, "R6 async clear");
        repeat (50) @(negedge clk);
        check(tmr_out, 1'b0, "R6 held in reset");

        // one-shot stage 16 start low
        restart(2'b11, 1'b0, 1'b0);
        push(32768, 1'b1, "R4 stage16");
        run_to(32800); close_case("R4 stage16");

        // R10 select switch mid-count: stage 8 -> stage 10 at edge 100
        restart(2'b10, 1'b1, 1'b0);
        run_to(100);
        #2 sel = 2'b01;
        push(512, 1'b1, "R10 new tap");
        run_to(520); close_case("R10");

        // R8 auto reset enabled: counting from power-up
        @(negedge clk); #2;
        mon_en = 1'b0; por_n = 1'b0; auto_off = 1'b0;
        sel = 2'b10; mode_recycle = 1'b1; start_high = 1'b0;
        repeat (3) @(negedge clk);
        #2 por_n = 1'b1;
        prev_out = 1'b0; mon_en = 1'b1;
        push(128, 1'b1, "R8 auto start");
        run_to(130); close_case("R8");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1900000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule